// File: doc/BRIEF.md
# Status Byte and Service Request Unit

This unit collects the status of an instrument into one 8-bit status byte and raises a service-request line when the controller needs to look at it. It has two groups of event flags, a standard group and an extended group. Each flag is set by a one-cycle event pulse and stays set until software reads that group. Each group has an enable mask, and a group feeds its summary bit into the status byte only through that mask. Two further status bits come straight from the "not empty" flags of an output queue and an error queue that sit outside the unit.

A service-request enable mask picks which status byte bits may ask for service. The masked OR of those bits is the master summary, a live level. A request latch sets on each rising edge of that summary and drives the service-request output. The latch clears when the controller performs a serial poll or when the summary drops. The status byte can be read two ways. A serial poll shows the request latch in bit 6 and consumes it. A plain status query shows the live master summary in bit 6 and leaves the latch alone.

Software reaches the unit through a small register port. A read is strobed by `rd_en` with an address, and `rd_data` appears one cycle later, flagged by `rd_valid`. A write is strobed by `wr_en`.

Top module: `status_svc_unit`

## Requirements
- R1: After reset every register is 0 and `srq` is 0. Status byte bits 7, 1 and 0 always read as 0.
- R2: Status byte bit 2 is 1 exactly while `err_q_not_empty` is 1.
- R3: Status byte bit 4 is 1 exactly while `out_q_not_empty` is 1.
- R4: Status byte bit 3 is 1 when some extended event flag and its extended enable bit are both 1.
- R5: Status byte bit 5 is 1 when some standard event flag and its standard enable bit are both 1.
- R6: The request latch sets on the clock edge after the master summary (OR over status bits 0..5 and 7, each ANDed with its service-request enable bit) rises from 0 to 1. `srq` equals the latch.
- R7: A read at address 1 (serial poll) returns the status byte with bit 6 equal to the request latch, and clears the latch.
- R8: The latch clears on the edge after the master summary is 0. It does not set again until the summary makes a new 0-to-1 transition.
- R9: A status bit whose service-request enable bit is 0 never causes a request, even while that status bit is 1.
- R10: A read at address 0 (status query) returns bit 6 equal to the master summary and leaves the latch unchanged.
- R11: Event flags are sticky. Address 3 reads the standard flags and address 5 reads the extended flags. Each such read returns the flags and then clears them.
- R12: An event pulse that arrives in the same cycle as a clearing read of its own group is kept. It shows up on the next read.
- R13: The enable registers can be written and read: service-request enable at address 2, standard enable at address 4, extended enable at address 6. Reading them does not change them.
- R14: Bit 6 of the service-request enable register has no effect on the master summary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 8 | Read data |
| std_evt_pulse | input | 8 | Standard event pulses, one bit per flag |
| ext_evt_pulse | input | 8 | Extended event pulses, one bit per flag |
| err_q_not_empty | input | 1 | Error queue holds an entry |
| out_q_not_empty | input | 1 | Output queue holds a response |
| srq | output | 1 | Service request, follows the request latch |

## Verification
The bench checks that a status query reports bit 6 as the live summary and does not consume a pending request. A design that returned the latch there, or cleared it, would report the wrong bit 6 or drop `srq` early. It checks that once a serial poll has cleared the latch, toggling another status bit while the summary stays high does not raise a new request. A level-triggered latch would fire again in that case. It also fires an event in the same cycle as the clearing read of its group: a design that let the clear win would lose that event. It sets enable bit 6 and the unused status positions to show that these never reach `srq` and never read as anything but 0.

// File: rtl/svc_pkg.sv
package svc_pkg;
    localparam int DATA_W = 8;
    localparam int STD_W  = 8;
    localparam int EXT_W  = 8;
    localparam int ADDR_W = 3;
    localparam int RQS_BIT = 6;

    typedef enum logic [ADDR_W-1:0] {
        A_STB_QUERY = 3'd0,
        A_SPOLL     = 3'd1,
        A_SRE       = 3'd2,
        A_STD_EVT   = 3'd3,
        A_STD_EN    = 3'd4,
        A_EXT_EVT   = 3'd5,
        A_EXT_EN    = 3'd6,
        A_NONE      = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic spare7;
        logic req;      // bit 6: RQS or MSS depending on read path
        logic esb;      // bit 5
        logic mav;      // bit 4
        logic ees;      // bit 3
        logic eav;      // bit 2
        logic spare1;
        logic spare0;
    } stb_t;

    function automatic stb_t build_stb(logic esb, logic mav, logic ees,
                                       logic eav, logic req);
        stb_t s;
        s = '0;
        s.esb = esb;
        s.mav = mav;
        s.ees = ees;
        s.eav = eav;
        s.req = req;
        return s;
    endfunction

    // enable bit 6 never contributes to the master summary
    function automatic logic [DATA_W-1:0] sre_effective(logic [DATA_W-1:0] sre);
        logic [DATA_W-1:0] m;
        m = sre;
        m[RQS_BIT] = 1'b0;
        return m;
    endfunction
endpackage

// File: rtl/svc_evt_group.sv
module svc_evt_group #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_pulse,
    input  logic         clr,
    input  logic         en_wr,
    input  logic [W-1:0] en_wdata,
    output logic [W-1:0] evt_q,
    output logic [W-1:0] en_q,
    output logic         summary
);
    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= '0;
            en_q  <= '0;
        end else begin
            // a pulse in the clearing cycle survives
            evt_q <= (clr ? '0 : evt_q) | set_pulse;
            if (en_wr) en_q <= en_wdata;
        end
    end

    assign summary = |(evt_q & en_q);

    // R11: flags are sticky while not cleared
    p_evt_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

    // R12: every pulse is captured, clear or not
    p_evt_capture_r12: assert property (@(posedge clk) disable iff (rst)
        (|set_pulse) |=> ((evt_q & $past(set_pulse)) == $past(set_pulse)));
endmodule

// File: rtl/svc_req_gen.sv
module svc_req_gen
    import svc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] stb_bits,
    input  logic [DATA_W-1:0] sre,
    input  logic              spoll,
    output logic              mss,
    output logic              rqs
);
    logic mss_q;

    assign mss = |(stb_bits & sre_effective(sre));

    always_ff @(posedge clk) begin
        if (rst) begin
            mss_q <= 1'b0;
            rqs   <= 1'b0;
        end else begin
            mss_q <= mss;
            rqs   <= mss && (!mss_q || (rqs && !spoll));
        end
    end

    // R6: a rising summary arms the request
    p_rqs_rise_r6: assert property (@(posedge clk) disable iff (rst)
        (mss && !mss_q) |=> rqs);

    // R8: a low summary drops the request
    p_rqs_drop_r8: assert property (@(posedge clk) disable iff (rst)
        !mss |=> !rqs);

    // R7: a poll without a fresh rise consumes the request
    p_poll_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (spoll && mss_q) |=> !rqs);
endmodule

// File: rtl/status_svc_unit.sv
module status_svc_unit
    import svc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic [STD_W-1:0]  std_evt_pulse,
    input  logic [EXT_W-1:0]  ext_evt_pulse,
    input  logic              err_q_not_empty,
    input  logic              out_q_not_empty,
    output logic              srq
);
    reg_addr_e        a;
    logic [STD_W-1:0] std_evt, std_en;
    logic [EXT_W-1:0] ext_evt, ext_en;
    logic             esb, ees, mss, rqs;
    logic [DATA_W-1:0] sre_q;
    stb_t             stb_base;
    logic             rd_std_evt, rd_ext_evt, rd_poll;

    assign a          = reg_addr_e'(addr);
    assign rd_std_evt = rd_en && (a == A_STD_EVT);
    assign rd_ext_evt = rd_en && (a == A_EXT_EVT);
    assign rd_poll    = rd_en && (a == A_SPOLL);

    svc_evt_group #(.W(STD_W)) u_std (
        .clk(clk), .rst(rst), .set_pulse(std_evt_pulse), .clr(rd_std_evt),
        .en_wr(wr_en && (a == A_STD_EN)), .en_wdata(wr_data[STD_W-1:0]),
        .evt_q(std_evt), .en_q(std_en), .summary(esb));

    svc_evt_group #(.W(EXT_W)) u_ext (
        .clk(clk), .rst(rst), .set_pulse(ext_evt_pulse), .clr(rd_ext_evt),
        .en_wr(wr_en && (a == A_EXT_EN)), .en_wdata(wr_data[EXT_W-1:0]),
        .evt_q(ext_evt), .en_q(ext_en), .summary(ees));

    always_ff @(posedge clk) begin
        if (rst) sre_q <= '0;
        else if (wr_en && (a == A_SRE)) sre_q <= wr_data;
    end

    assign stb_base = build_stb(esb, out_q_not_empty, ees, err_q_not_empty, 1'b0);

    svc_req_gen u_req (
        .clk(clk), .rst(rst), .stb_bits(stb_base), .sre(sre_q),
        .spoll(rd_poll), .mss(mss), .rqs(rqs));

    assign srq = rqs;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                unique case (a)
                    A_STB_QUERY: rd_data <= build_stb(esb, out_q_not_empty, ees, err_q_not_empty, mss);
                    A_SPOLL:     rd_data <= build_stb(esb, out_q_not_empty, ees, err_q_not_empty, rqs);
                    A_SRE:       rd_data <= sre_q;
                    A_STD_EVT:   rd_data <= DATA_W'(std_evt);
                    A_STD_EN:    rd_data <= DATA_W'(std_en);
                    A_EXT_EVT:   rd_data <= DATA_W'(ext_evt);
                    A_EXT_EN:    rd_data <= DATA_W'(ext_en);
                    default:     rd_data <= '0;
                endcase
            end
        end
    end

    // R10: a status query leaves a pending request in place
    p_query_keeps_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (a == A_STB_QUERY) && rqs && mss) |=> srq);

    // R1: unused status positions stay zero on status reads
    p_spare_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (rd_en && ((a == A_STB_QUERY) || (a == A_SPOLL)))
            |=> (rd_data[7] == 1'b0 && rd_data[1:0] == 2'b00));
endmodule

// File: tb/sim_status_svc_unit.sv
module sim_status_svc_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic [7:0] std_p = 8'd0, ext_p = 8'd0;
    logic       err_ne = 1'b0, out_ne = 1'b0;
    logic       srq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    typedef struct { logic [7:0] exp; string tag; } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;   // 250 MHz

    status_svc_unit u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data),
        .std_evt_pulse(std_p), .ext_evt_pulse(ext_p),
        .err_q_not_empty(err_ne), .out_q_not_empty(out_ne), .srq(srq));

    // monitor: pop and compare each returned read
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            n_checks++;
            if (sb_q.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected read data actual=%h expected=none", rd_data);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (rd_data !== e.exp) begin
                    n_fail++;
                    $display("FAIL %s rd_data actual=%h expected=%h", e.tag, rd_data, e.exp);
                end
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        idle(2);
    endtask

    task automatic rd(logic [2:0] a, logic [7:0] exp, string tag);
        exp_t e;
        e.exp = exp; e.tag = tag;
        sb_q.push_back(e);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_std(logic [7:0] v);
        std_p = v; @(negedge clk); std_p = 8'd0; idle(2);
    endtask

    task automatic pulse_ext(logic [7:0] v);
        ext_p = v; @(negedge clk); ext_p = 8'd0; idle(2);
    endtask

    task automatic chk_srq(logic exp, string tag);
        n_checks++;
        if (srq !== exp) begin
            n_fail++;
            $display("FAIL %s srq actual=%b expected=%b", tag, srq, exp);
        end
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk_srq(1'b0, "R1");
        rd(3'd0, 8'h00, "R1 status after reset");
        rd(3'd2, 8'h00, "R1 sre after reset");

        // R5 / R9 standard group, masked request
        wr(3'd4, 8'h10);
        pulse_std(8'h10);
        rd(3'd0, 8'h20, "R5 esb");
        idle(1);
        chk_srq(1'b0, "R9 masked esb");

        // R6 rising summary
        wr(3'd2, 8'h20);
        idle(1);
        chk_srq(1'b1, "R6 request raised");
        rd(3'd0, 8'h60, "R10 query shows mss");
        idle(1);
        chk_srq(1'b1, "R10 query keeps request");
        rd(3'd1, 8'h60, "R7 poll shows rqs");
        chk_srq(1'b0, "R7 poll clears");
        rd(3'd1, 8'h20, "R7 second poll rqs low");

        // R13 / R11
        rd(3'd4, 8'h10, "R13 enable read");
        rd(3'd4, 8'h10, "R13 enable kept");
        rd(3'd3, 8'h10, "R11 std flags");
        rd(3'd3, 8'h00, "R11 std flags cleared");
        rd(3'd0, 8'h00, "R11 esb gone");

        // R4 extended group
        wr(3'd6, 8'h01);
        pulse_ext(8'h02);
        rd(3'd0, 8'h00, "R4 disabled ext flag");
        pulse_ext(8'h01);
        rd(3'd0, 8'h08, "R4 ees");
        wr(3'd2, 8'h08);
        idle(1);
        chk_srq(1'b1, "R6 ees request");
        rd(3'd5, 8'h03, "R11 ext flags");
        idle(2);
        chk_srq(1'b0, "R8 summary fall clears");
        rd(3'd0, 8'h00, "R4 ees gone");

        // R2 / R3 queue flags
        err_ne = 1'b1; idle(1);
        rd(3'd0, 8'h04, "R2 eav");
        out_ne = 1'b1; idle(1);
        rd(3'd0, 8'h14, "R3 mav");
        wr(3'd2, 8'h04);
        idle(1);
        chk_srq(1'b1, "R6 eav request");
        rd(3'd1, 8'h54, "R7 poll with eav");
        chk_srq(1'b0, "R7 poll clears eav request");
        out_ne = 1'b0; idle(2); out_ne = 1'b1; idle(2);
        chk_srq(1'b0, "R8 no retrigger while summary high");
        err_ne = 1'b0; idle(2); err_ne = 1'b1; idle(3);
        chk_srq(1'b1, "R6 new rise rearms");
        rd(3'd1, 8'h54, "R7 poll after rearm");

        // R14 enable bit 6 ignored
        wr(3'd2, 8'h40);
        idle(1);
        rd(3'd0, 8'h14, "R14 bit6 enable no mss");
        idle(1);
        chk_srq(1'b0, "R14 no request");

        // R1 unused positions with everything enabled and set
        wr(3'd2, 8'hFF);
        wr(3'd4, 8'hFF);
        wr(3'd6, 8'hFF);
        std_p = 8'hFF; ext_p = 8'hFF; @(negedge clk);
        std_p = 8'h00; ext_p = 8'h00; idle(2);
        rd(3'd0, 8'h7C, "R1 spare bits zero");
        rd(3'd1, 8'h7C, "R1 poll spare bits zero");
        rd(3'd5, 8'hFF, "R11 all ext flags");
        rd(3'd3, 8'hFF, "R11 all std flags");

        // R12 event coincident with clearing read
        pulse_std(8'h04);
        std_p = 8'h01;
        rd(3'd3, 8'h04, "R12 read returns old flags");
        std_p = 8'h00;
        rd(3'd3, 8'h01, "R12 coincident event kept");
        rd(3'd3, 8'h00, "R12 then cleared");

        idle(3);
        n_checks++;
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL R11 missing reads actual=%0d expected=0", sb_q.size());
        end
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule